// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block controls a bank of general-purpose pins through a small word-addressed register port. Software changes the output data and the pin direction with atomic write-one-to-set and write-one-to-clear strobes, so no read-modify-write sequence is needed. Incoming pin levels pass through a synchronizer and are compared with their value one cycle earlier. Rising and falling transitions are qualified by separate enable masks and latched into an event status register, which drives a combined interrupt line.

A second, independent pair of rising and falling masks marks transitions as wake events. These are latched apart from the interrupt status and drive a wake line. One write-one-to-clear register clears both latches. Per-pin function select bits and pull-disable bits are plain storage, brought out to the pin multiplexer and pad ring. All registers are word addresses on a 5-bit address. Reads of write-only addresses return zero, and bits above the implemented pin count read as zero.

Top module: `gpio_edge_bank`

## Requirements
- R1: The pin count is the parameter NUM_PINS (default 32). Register bits at positions NUM_PINS and above always read as zero, even after all-ones writes.
- R2: A write to address 2 (output set) drives high every pin whose data bit is 1. A write to address 3 (output clear) drives low every pin whose bit is 1. Zero bits leave their pins unchanged. Address 1 reads back the output data, and `pin_out` carries it.
- R3: A write to address 5 (direction set) makes the selected pins outputs, and a write to address 6 (direction clear) makes them inputs. Address 4 reads the direction, with 1 meaning output. `pin_oe` carries the same value.
- R4: Address 0 returns the pin level after a synchronizer of SYNC_STAGES flops (default 2). A pin change made before clock edge k is visible after edge k+1 and not after edge k.
- R5: Address 7 holds the rising-edge enable mask and address 8 the falling-edge enable mask. An enabled transition sets the pin's bit in the status register (address 11). A pin with both bits set latches on either edge. A transition with its enable bit at 0 latches nothing.
- R6: Writing a 1 to a bit of address 13 (event clear) clears that bit in both the status register and the wake register. Zero bits keep their state.
- R7: Detection is edge-only. A pin held high latches a single event, and after a clear it does not latch again while the level stays constant.
- R8: Addresses 9 and 10 hold the wake rising and wake falling masks. Wake-enabled transitions set bits in the wake register (address 12), and the `wake` output is high while any of those bits is set. The wake masks do not affect the status register or `irq`, and the interrupt masks do not affect the wake register.
- R9: Addresses 14 and 15 store the per-pin function select bits A and B. They are read back and drive `func_a` and `func_b`. The encoding is: neither bit set = GPIO, A only = function A, B only = function B, both set = function C.
- R10: Address 16 stores the per-pin pull-disable bits (1 = pull off). They are read back and drive `pull_dis`.
- R11: `irq` is high exactly when at least one status bit is set. All registers and both outputs are zero after reset.
- R12: If a latched transition and an event-clear write hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels from the pads |
| pin_out | output | NUM_PINS | Output data to the pads |
| pin_oe | output | NUM_PINS | Output enable per pin (1 = output) |
| func_a | output | NUM_PINS | Function select bit A per pin |
| func_b | output | NUM_PINS | Function select bit B per pin |
| pull_dis | output | NUM_PINS | Pull disable per pin |
| irq | output | 1 | Any interrupt status bit set |
| wake | output | 1 | Any wake status bit set |

## Verification
The edge logic is driven with several patterns. Simultaneous rises on pins with only a rising enable, only a falling enable, both enables and no enable show that the two masks are independent and that disabled edges are dropped. The matching falls then separate falling from rising detection. A pin held high across a clear distinguishes edge detection from level detection, and a rise on a wake-only pin next to a rise on an interrupt-only pin shows that the two mask pairs feed separate latches. A clear timed to land in the same cycle as a detected edge settles the priority between them. Bench sampling at one and two edges after a pin change pins down the synchronizer depth.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int REG_AW = 5;

   typedef enum logic [REG_AW-1:0] {
      REG_LEVEL     = 5'd0,
      REG_OUT       = 5'd1,
      REG_OUT_SET   = 5'd2,
      REG_OUT_CLR   = 5'd3,
      REG_DIR       = 5'd4,
      REG_DIR_SET   = 5'd5,
      REG_DIR_CLR   = 5'd6,
      REG_RISE_EN   = 5'd7,
      REG_FALL_EN   = 5'd8,
      REG_WRISE_EN  = 5'd9,
      REG_WFALL_EN  = 5'd10,
      REG_IRQ_STAT  = 5'd11,
      REG_WAKE_STAT = 5'd12,
      REG_EVT_CLR   = 5'd13,
      REG_FUNC_A    = 5'd14,
      REG_FUNC_B    = 5'd15,
      REG_PULL_OFF  = 5'd16
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] level_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync_edge: STAGES must be at least 2");
   end

   logic [N-1:0] chain_q [STAGES];
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
         prev_q <= '0;
      end else begin
         chain_q[0] <= pin_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         prev_q <= chain_q[LAST];
      end
   end

   assign level_o = chain_q[LAST];
   assign rise_o  = chain_q[LAST] & ~prev_q;
   assign fall_o  = ~chain_q[LAST] & prev_q;
endmodule

// File: rtl/gpio_set_clr_reg.sv
module gpio_set_clr_reg #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R2

   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0)); // R6

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(q_o)); // R6

   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_i & clr_i)) |=> ((q_o & $past(set_i & clr_i)) == $past(set_i & clr_i))); // R12
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_bank_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [REG_AW-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] func_a,
   output logic [NUM_PINS-1:0] func_b,
   output logic [NUM_PINS-1:0] pull_dis,
   output logic                irq,
   output logic                wake
);
   localparam int NP = NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_edge_bank: NUM_PINS must lie in 1..DATA_W");
   end

   logic [NP-1:0] wmask;
   logic [NP-1:0] level, rise, fall;
   logic [NP-1:0] rise_en_q, fall_en_q, wrise_en_q, wfall_en_q;
   logic [NP-1:0] irq_set, wake_set, evt_clr;
   logic [NP-1:0] irq_stat, wake_stat;
   logic [NP-1:0] out_set, out_clr, dir_set, dir_clr;
   logic [NP-1:0] rd_pins;

   assign wmask = bus_wdata[NP-1:0];

   function automatic logic hit(input logic [REG_AW-1:0] a, input gpio_reg_e r);
      return a == r;
   endfunction

   assign out_set = (bus_wr && hit(bus_addr, REG_OUT_SET)) ? wmask : '0;
   assign out_clr = (bus_wr && hit(bus_addr, REG_OUT_CLR)) ? wmask : '0;
   assign dir_set = (bus_wr && hit(bus_addr, REG_DIR_SET)) ? wmask : '0;
   assign dir_clr = (bus_wr && hit(bus_addr, REG_DIR_CLR)) ? wmask : '0;
   assign evt_clr = (bus_wr && hit(bus_addr, REG_EVT_CLR)) ? wmask : '0;

   gpio_sync_edge #(.N(NP), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_in),
      .level_o(level), .rise_o(rise), .fall_o(fall));

   gpio_set_clr_reg #(.N(NP)) u_out (
      .clk(clk), .rst_n(rst_n), .set_i(out_set), .clr_i(out_clr), .q_o(pin_out));

   gpio_set_clr_reg #(.N(NP)) u_dir (
      .clk(clk), .rst_n(rst_n), .set_i(dir_set), .clr_i(dir_clr), .q_o(pin_oe));

   assign irq_set  = (rise & rise_en_q)  | (fall & fall_en_q);
   assign wake_set = (rise & wrise_en_q) | (fall & wfall_en_q);

   gpio_set_clr_reg #(.N(NP)) u_irq_stat (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(evt_clr), .q_o(irq_stat));

   gpio_set_clr_reg #(.N(NP)) u_wake_stat (
      .clk(clk), .rst_n(rst_n), .set_i(wake_set), .clr_i(evt_clr), .q_o(wake_stat));

   // Plain read/write storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en_q  <= '0;
         fall_en_q  <= '0;
         wrise_en_q <= '0;
         wfall_en_q <= '0;
         func_a     <= '0;
         func_b     <= '0;
         pull_dis   <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            REG_RISE_EN:  rise_en_q  <= wmask;
            REG_FALL_EN:  fall_en_q  <= wmask;
            REG_WRISE_EN: wrise_en_q <= wmask;
            REG_WFALL_EN: wfall_en_q <= wmask;
            REG_FUNC_A:   func_a     <= wmask;
            REG_FUNC_B:   func_b     <= wmask;
            REG_PULL_OFF: pull_dis   <= wmask;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         REG_LEVEL:     rd_pins = level;
         REG_OUT:       rd_pins = pin_out;
         REG_DIR:       rd_pins = pin_oe;
         REG_RISE_EN:   rd_pins = rise_en_q;
         REG_FALL_EN:   rd_pins = fall_en_q;
         REG_WRISE_EN:  rd_pins = wrise_en_q;
         REG_WFALL_EN:  rd_pins = wfall_en_q;
         REG_IRQ_STAT:  rd_pins = irq_stat;
         REG_WAKE_STAT: rd_pins = wake_stat;
         REG_FUNC_A:    rd_pins = func_a;
         REG_FUNC_B:    rd_pins = func_b;
         REG_PULL_OFF:  rd_pins = pull_dis;
         default:       rd_pins = '0;
      endcase
   end

   assign bus_rdata = DATA_W'(rd_pins);
   assign irq       = |irq_stat;
   assign wake      = |wake_stat;

   if (NUM_PINS < DATA_W) begin : g_unimpl_chk
      AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rdata[DATA_W-1:NUM_PINS] == '0); // R1
   end

   AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|irq_set)); // R5

   AST_WAKE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake) |-> $past(|wake_set)); // R8

   AST_IRQ_DROPS_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(|evt_clr)); // R11
endmodule

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/1ps
module gpio_edge_bank_bench;
   localparam int NP = 20;
   localparam int DW = 32;
   localparam logic [DW-1:0] PMASK = (DW'(1) << NP) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe, func_a, func_b, pull_dis;
   logic          irq, wake;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   gpio_edge_bank #(.DATA_W(DW), .NUM_PINS(NP), .SYNC_STAGES(2)) u_gpio_edge_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .func_a(func_a), .func_b(func_b),
      .pull_dis(pull_dis), .irq(irq), .wake(wake));

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic quiet();
      pin_in = '0;
      settle();
      wr(5'd7, 0); wr(5'd8, 0); wr(5'd9, 0); wr(5'd10, 0);
      wr(5'd13, PMASK);
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      rd(5'd1, v);  check("R11 out after reset", v, 0);
      rd(5'd4, v);  check("R11 dir after reset", v, 0);
      rd(5'd11, v); check("R11 status after reset", v, 0);
      check("R11 irq/wake after reset", {30'd0, irq, wake}, 0);
   endtask

   task automatic t_data();
      logic [DW-1:0] v;
      wr(5'd2, 32'hFFFF_FFFF);
      rd(5'd1, v); check("R1 upper bits zero", v, 32'h000F_FFFF);
      check("R2 pin_out all high", DW'(pin_out), 32'h000F_FFFF);
      wr(5'd3, 32'h0000_0F0F);
      rd(5'd1, v); check("R2 clear selected", v, 32'h000F_F0F0);
      wr(5'd2, 0);
      rd(5'd1, v); check("R2 zero set bits no change", v, 32'h000F_F0F0);
      wr(5'd3, 0);
      check("R2 zero clear bits no change", DW'(pin_out), 32'h000F_F0F0);
   endtask

   task automatic t_dir();
      logic [DW-1:0] v;
      wr(5'd5, 32'h0000_00A5);
      rd(5'd4, v); check("R3 dir set", v, 32'hA5);
      wr(5'd6, 32'h0000_0005);
      rd(5'd4, v); check("R3 dir clear", v, 32'hA0);
      check("R3 pin_oe", DW'(pin_oe), 32'hA0);
   endtask

   task automatic t_level();
      logic [DW-1:0] v;
      bus_addr = 5'd0;
      @(negedge clk); pin_in = 20'h12345;
      @(negedge clk); #0.5 check("R4 not yet after one edge", bus_rdata, 0);
      @(negedge clk); #0.5 check("R4 visible after two edges", bus_rdata, 32'h12345);
      rd(5'd11, v); check("R5 no latch with masks off", v, 0);
      quiet();
   endtask

   task automatic t_edges();
      logic [DW-1:0] v;
      wr(5'd7, 32'h5);   // pin0 rise, pin2 rise
      wr(5'd8, 32'h6);   // pin1 fall, pin2 fall
      pin_in = 20'hF;
      settle();
      rd(5'd11, v); check("R5 rising enables", v, 32'h5);
      check("R11 irq with status", DW'(irq), 1);
      wr(5'd13, 32'h7);
      rd(5'd11, v); check("R6 clear all", v, 0);
      check("R11 irq low when clear", DW'(irq), 0);
      pin_in = 20'h0;
      settle();
      rd(5'd11, v); check("R5 falling enables", v, 32'h6);
      wr(5'd13, 32'h2);
      rd(5'd11, v); check("R6 zero bits keep", v, 32'h4);
      quiet();
   endtask

   task automatic t_no_level();
      logic [DW-1:0] v;
      wr(5'd7, 32'h1);
      pin_in = 20'h1;
      settle();
      rd(5'd11, v); check("R7 one event on rise", v, 32'h1);
      wr(5'd13, 32'h1);
      repeat (10) @(negedge clk);
      rd(5'd11, v); check("R7 steady high no relatch", v, 0);
      quiet();
   endtask

   task automatic t_wake();
      logic [DW-1:0] v;
      wr(5'd9, 32'h10);  // wake rise pin4
      wr(5'd7, 32'h20);  // irq rise pin5
      pin_in = 20'h30;
      settle();
      rd(5'd12, v); check("R8 wake latch only wake pin", v, 32'h10);
      rd(5'd11, v); check("R8 status only irq pin", v, 32'h20);
      check("R8 wake output high", DW'(wake), 1);
      wr(5'd13, 32'h10);
      check("R8 wake cleared", DW'(wake), 0);
      check("R6 irq bit kept", DW'(irq), 1);
      quiet();
   endtask

   task automatic t_storage();
      logic [DW-1:0] v;
      wr(5'd14, 32'h3);
      wr(5'd15, 32'h5);
      rd(5'd14, v); check("R9 func A readback", v, 32'h3);
      rd(5'd15, v); check("R9 func B readback", v, 32'h5);
      check("R9 pin0 function C", {30'd0, func_a[0], func_b[0]}, 32'h3);
      check("R9 pin1 function A", {30'd0, func_a[1], func_b[1]}, 32'h2);
      wr(5'd16, 32'hFFFA_BCDE);
      rd(5'd16, v); check("R10 pull-off readback", v, 32'h000A_BCDE);
      check("R10 pull_dis port", DW'(pull_dis), 32'h000A_BCDE);
   endtask

   task automatic t_edge_wins();
      logic [DW-1:0] v;
      wr(5'd7, 32'h100);
      wr(5'd13, 32'h100);
      rd(5'd11, v); check("R12 control clear without edge", v, 0);
      @(negedge clk); pin_in = 20'h100;
      @(posedge clk); @(posedge clk);
      wr(5'd13, 32'h100);  // lands on the edge that latches the rise
      rd(5'd11, v); check("R12 edge beats clear", v, 32'h100);
      quiet();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data();
      t_dir();
      t_level();
      t_edges();
      t_no_level();
      t_wake();
      t_storage();
      t_edge_wins();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule